// File: doc/BRIEF.md
# Trap Cause Register

This block holds the machine trap cause word for a 32-bit machine-mode core whose interrupts come from a level-based controller. When the core takes a trap, the register records four things in a single clock edge. The first is whether the trap was an interrupt. The second is a 12-bit cause code: for interrupts this comes from the interrupt source, and for synchronous exceptions it comes from a fixed priority pick among the pending exception flags. The third is the saved interrupt-enable bit. The fourth is the saved interrupt level.

Software reads and writes the same word through a CSR port. The saved interrupt-enable bit is shared with the status register, and the block exports its current value so that the status register can show it. The status register's own writes to that bit also arrive here, so both views always agree. The saved-privilege field always reads as machine mode.

A mode input selects between level-based interrupt mode and the legacy mode. While the legacy mode is selected, the interrupt-level field is held at zero, so a switch into legacy mode clears it.

Top module: `trap_cause_reg`

## Requirements
- R1: After reset, `csr_rdata` reads 32'h3000_0000 and `mpie_o` is 0.
- R2: The reserved bits 26:24 and 15:12 always read as 0. Bits 29:28 always read as 2'b11. CSR writes to these bits have no effect.
- R3: The bit index of `exc_req` gives the exception's priority, with bit 0 the highest. The mapping from bit to code is:
  - bit 0, instruction breakpoint: code 3.
  - bit 1, instruction access fault: code 1.
  - bit 2, illegal instruction: code 2.
  - bit 3, instruction misaligned: code 0.
  - bit 4, environment break: code 3.
  - bit 5, data breakpoint: code 3.
  - bit 6, data access fault: code 5, or code 7 when `is_store` is 1.
  - bit 7, data misaligned: code 4, or code 6 when `is_store` is 1.
- R4: When several `exc_req` bits are set, only the code of the lowest set bit index is recorded in bits 11:0.
- R5: An interrupt trap (`trap_take` and `irq_take` both 1) sets bit 31 to 1. The code is set as follows:
  - `irq_kind` 0 gives code 3.
  - `irq_kind` 1 gives code 7.
  - `irq_kind` 2 or 3 gives code 16 + `irq_line`, which spans 16 to 2063.
  
  An interrupt takes precedence over any exception flags pending in the same cycle.
- R6: An exception trap (`trap_take` is 1, `irq_take` is 0, and some `exc_req` bit is set) sets bit 31 to 0. Every trap writes bit 30 as 0.
- R7: On a trap, bit 27 takes the value of `prev_pie`. Bits 23:16 take the value of `prev_pil` when `clic_mode` is 1, and take 0 when it is 0.
- R8: Bit 27 and `mpie_o` are one bit of state. A status write (`mst_we`) sets it to `mst_mpie_wdata`. A CSR write sets it to `csr_wdata[27]`. If both writes fall in the same cycle, the CSR write wins.
- R9: One edge after the cycle in which `clic_mode` is 0, bits 23:16 read 0. While `clic_mode` is 0, CSR writes to those bits are ignored.
- R10: The register changes only on a trap, a CSR write, a status write, or a low `clic_mode`. A `trap_take` with no interrupt and no exception flag leaves the register unchanged.
- R11: When `trap_take` and `csr_we` fall in the same cycle, only the trap update is applied.
- R12: A CSR write with no trap stores bits 31, 30 and 11:0 exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clic_mode | input | 1 | 1 = level-based interrupt mode, 0 = legacy mode |
| trap_take | input | 1 | The core takes a trap this cycle |
| exc_req | input | 8 | Pending synchronous exception flags, indexed by priority |
| is_store | input | 1 | The data-side exception comes from a store |
| irq_take | input | 1 | The trap being taken is an interrupt |
| irq_kind | input | 2 | Interrupt source: 0 software, 1 timer, 2 or 3 platform line |
| irq_line | input | 11 | Platform interrupt line index |
| prev_pie | input | 1 | Interrupt enable to save on a trap |
| prev_pil | input | 8 | Interrupt level to save on a trap |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | Current cause word |
| mst_we | input | 1 | Status-register write to the shared enable bit |
| mst_mpie_wdata | input | 1 | Value of that status write |
| mpie_o | output | 1 | Shared saved-enable bit, for the status register |

## Verification
A trap can coincide with a CSR write. A trap, a CSR write and a status write can all target the shared enable bit in the same cycle. An interrupt and exception flags can be presented in the same trap cycle. Directed vectors force each of these collisions, and the random phase raises all the strobes independently so that they often overlap. A bench model applies the stated order of precedence and compares the whole word and `mpie_o` one edge later. Mode drops are mixed into the random phase to catch the level field being written during legacy mode.

// File: rtl/trap_cause_reg.sv
module trap_cause_reg #(
  parameter int PLAT_LINES = 2048,
  parameter int PLAT_BASE  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clic_mode,
  input  logic        trap_take,
  input  logic [7:0]  exc_req,
  input  logic        is_store,
  input  logic        irq_take,
  input  logic [1:0]  irq_kind,
  input  logic [10:0] irq_line,
  input  logic        prev_pie,
  input  logic [7:0]  prev_pil,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        mst_we,
  input  logic        mst_mpie_wdata,
  output logic        mpie_o
);
  localparam int LINE_W = $clog2(PLAT_LINES);
  localparam int CODE_W = 12;

  logic              intr_q, minhv_q, mpie_q;
  logic [7:0]        lvl_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] exc_code, irq_code;
  logic              exc_hit, trap_upd;

  function automatic logic [CODE_W-1:0] rank_code(input int r, input logic st);
    case (r)
      0: return CODE_W'(3);
      1: return CODE_W'(1);
      2: return CODE_W'(2);
      3: return CODE_W'(0);
      4: return CODE_W'(3);
      5: return CODE_W'(3);
      6: return st ? CODE_W'(7) : CODE_W'(5);
      default: return st ? CODE_W'(6) : CODE_W'(4);
    endcase
  endfunction

  assign exc_hit = |exc_req;

  always_comb begin
    exc_code = '0;
    for (int r = 7; r >= 0; r--)
      if (exc_req[r]) exc_code = rank_code(r, is_store);
  end

  always_comb begin
    case (irq_kind)
      2'd0:    irq_code = CODE_W'(3);
      2'd1:    irq_code = CODE_W'(7);
      default: irq_code = CODE_W'(PLAT_BASE) + CODE_W'(irq_line[LINE_W-1:0]);
    endcase
  end

  assign trap_upd = trap_take && (irq_take || exc_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intr_q  <= 1'b0;
      minhv_q <= 1'b0;
      mpie_q  <= 1'b0;
      code_q  <= '0;
    end else if (trap_upd) begin
      intr_q  <= irq_take;
      minhv_q <= 1'b0;
      mpie_q  <= prev_pie;
      code_q  <= irq_take ? irq_code : exc_code;
    end else if (csr_we) begin
      intr_q  <= csr_wdata[31];
      minhv_q <= csr_wdata[30];
      mpie_q  <= csr_wdata[27];
      code_q  <= csr_wdata[CODE_W-1:0];
    end else if (mst_we) begin
      mpie_q  <= mst_mpie_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !clic_mode) lvl_q <= '0;
    else if (trap_upd)        lvl_q <= prev_pil;
    else if (csr_we)          lvl_q <= csr_wdata[23:16];
  end

  assign csr_rdata = {intr_q, minhv_q, 2'b11, mpie_q, 3'b000, lvl_q, 4'b0000, code_q};
  assign mpie_o    = mpie_q;

  a_r5_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && irq_take) |=> csr_rdata[31]);
  a_r6_exc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && !irq_take && |exc_req) |=> (csr_rdata[31:30] == 2'b00));
  a_r9_lvl_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clic_mode |=> (csr_rdata[23:16] == 8'h00));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !csr_we && !mst_we && clic_mode) |=> $stable(csr_rdata));
  a_r8_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_we && !trap_take && !csr_we) |=> (mpie_o == $past(mst_mpie_wdata)));
  a_r11_csr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !trap_take) |=> (csr_rdata[11:0] == $past(csr_wdata[11:0])));
  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (csr_rdata[29:24] == 6'b110000 || csr_rdata[29:24] == 6'b111000));
endmodule

// File: tb/trap_cause_reg_tb.sv
module trap_cause_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        clic_mode = 1'b1, trap_take = 1'b0, is_store = 1'b0, irq_take = 1'b0;
  logic [7:0]  exc_req = '0, prev_pil = '0;
  logic [1:0]  irq_kind = '0;
  logic [10:0] irq_line = '0;
  logic        prev_pie = 1'b0, csr_we = 1'b0, mst_we = 1'b0, mst_mpie_wdata = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        mpie_o;

  int nvec = 0, nbad = 0;
  bit done = 0;

  logic        e_intr = 0, e_minhv = 0, e_pie = 0;
  logic [7:0]  e_lvl = 0;
  logic [11:0] e_code = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_cause_reg u_dut (
    .clk(clk), .rst_n(rst_n), .clic_mode(clic_mode), .trap_take(trap_take),
    .exc_req(exc_req), .is_store(is_store), .irq_take(irq_take), .irq_kind(irq_kind),
    .irq_line(irq_line), .prev_pie(prev_pie), .prev_pil(prev_pil), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mst_we(mst_we),
    .mst_mpie_wdata(mst_mpie_wdata), .mpie_o(mpie_o)
  );

  function automatic logic [11:0] exp_exc(input logic [7:0] f, input logic st);
    if (f[0]) return 12'd3;
    if (f[1]) return 12'd1;
    if (f[2]) return 12'd2;
    if (f[3]) return 12'd0;
    if (f[4]) return 12'd3;
    if (f[5]) return 12'd3;
    if (f[6]) return st ? 12'd7 : 12'd5;
    return st ? 12'd6 : 12'd4;
  endfunction

  function automatic logic [11:0] exp_irq(input logic [1:0] k, input logic [10:0] n);
    if (k == 2'd0) return 12'd3;
    if (k == 2'd1) return 12'd7;
    return 12'd16 + {1'b0, n};
  endfunction

  function automatic logic [31:0] word();
    return {e_intr, e_minhv, 2'b11, e_pie, 3'b000, e_lvl, 4'b0000, e_code};
  endfunction

  task automatic model_step();
    logic t;
    t = trap_take && (irq_take || (exc_req != 0));
    if (t) begin
      e_intr = irq_take; e_minhv = 0; e_pie = prev_pie;
      e_code = irq_take ? exp_irq(irq_kind, irq_line) : exp_exc(exc_req, is_store);
    end else if (csr_we) begin
      e_intr = csr_wdata[31]; e_minhv = csr_wdata[30]; e_pie = csr_wdata[27];
      e_code = csr_wdata[11:0];
    end else if (mst_we) e_pie = mst_mpie_wdata;
    if (!clic_mode) e_lvl = 0;
    else if (t) e_lvl = prev_pil;
    else if (csr_we) e_lvl = csr_wdata[23:16];
  endtask

  task automatic quiet();
    trap_take = 0; irq_take = 0; exc_req = 0; csr_we = 0; mst_we = 0;
  endtask

  task automatic apply(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    nvec++;
    if (csr_rdata !== word() || mpie_o !== e_pie) begin
      nbad++;
      $display("FAIL %s: rdata=%h mpie=%b expected rdata=%h mpie=%b",
               tag, csr_rdata, mpie_o, word(), e_pie);
    end
    quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250525));
    repeat (3) @(negedge clk);
    nvec++;
    if (csr_rdata !== 32'h3000_0000 || mpie_o !== 1'b0) begin
      nbad++;
      $display("FAIL R1: rdata=%h mpie=%b expected 30000000 0", csr_rdata, mpie_o);
    end
    rst_n = 1;

    // R3 / R4: priority and store selection
    trap_take = 1; exc_req = 8'hFF; is_store = 1; apply("R4 all flags");
    trap_take = 1; exc_req = 8'hC0; is_store = 1; apply("R4 store access over misaligned");
    trap_take = 1; exc_req = 8'h80; is_store = 0; apply("R3 load misaligned");
    trap_take = 1; exc_req = 8'h0C; apply("R4 illegal over misaligned fetch");
    trap_take = 1; exc_req = 8'h08; prev_pie = 1; prev_pil = 8'h5A; apply("R7 save state");
    // R5: interrupt codes, line bounds, interrupt beats exception
    trap_take = 1; irq_take = 1; irq_kind = 2; irq_line = 11'd2047; apply("R5 top line");
    trap_take = 1; irq_take = 1; irq_kind = 3; irq_line = 11'd0; apply("R5 line zero");
    trap_take = 1; irq_take = 1; irq_kind = 1; exc_req = 8'h01; apply("R5 timer over exception");
    trap_take = 1; irq_take = 0; exc_req = 8'h10; apply("R6 exception flag low");
    // R12 / R2: CSR write all ones
    csr_we = 1; csr_wdata = 32'hFFFF_FFFF; apply("R12 R2 write all ones");
    // R10: trap with nothing pending
    trap_take = 1; apply("R10 empty trap");
    // R11: trap and CSR write together
    trap_take = 1; irq_take = 1; irq_kind = 0; csr_we = 1; csr_wdata = 32'h4000_0ABC;
    prev_pie = 0; apply("R11 trap beats csr");
    // R8: status write, then collision with CSR write
    mst_we = 1; mst_mpie_wdata = 1; apply("R8 status write");
    mst_we = 1; mst_mpie_wdata = 1; csr_we = 1; csr_wdata = 32'h0012_0005; apply("R8 csr beats status");
    // R9: leave level mode, write ignored
    clic_mode = 0; csr_we = 1; csr_wdata = 32'h00FF_0001; apply("R9 mode drop clears level");
    trap_take = 1; exc_req = 8'h02; prev_pil = 8'hAA; apply("R7 legacy trap level zero");
    clic_mode = 1; apply("R9 hold after return");

    for (int i = 0; i < 3000; i++) begin
      trap_take      = ($urandom % 2) == 0;
      irq_take       = ($urandom % 3) == 0;
      irq_kind       = 2'($urandom);
      irq_line       = 11'($urandom);
      exc_req        = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom) & 8'($urandom);
      is_store       = 1'($urandom);
      prev_pie       = 1'($urandom);
      prev_pil       = 8'($urandom);
      csr_we         = ($urandom % 4) == 0;
      csr_wdata      = $urandom;
      mst_we         = ($urandom % 4) == 0;
      mst_mpie_wdata = 1'($urandom);
      if (($urandom % 10) == 0) clic_mode = ~clic_mode;
      apply("R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule